// File: doc/BRIEF.md
# Carrier Interrupt and Control Registers

This block is the register and interrupt hub of a six-slot module carrier. Each slot has two active-low interrupt request lines, so twelve in all. The block synchronizes these lines and shows their pending state in a read-only register. It merges them with a latched bus-timeout flag and a software test bit into one active-low local interrupt output, which an enable bit gates.

A single 16-bit control register drives three groups of outputs: one clock-speed select bit per slot, the enable for the bus-timeout auto-acknowledge, and the interrupt control bits. The timeout flag is sticky. It is cleared, and held cleared, for as long as the control register's arm bit is 0. There is no write-one-to-clear for it. Software cannot clear module pending bits: they fall only when the module releases its request line.

Host access uses a plain word port with an address, a write strobe, write data and combinational read data. Reset is synchronous and active-high.

Top module: `carrier_irq_ctrl`

## Requirements
- R1: The control register sits at offset 0x500 and is read/write on bits 9:0. Bits 15:10 always read 0, and the register resets to 0x0000.
- R2: Output `slot_clk_fast[s]` follows control bit s for slots 0 to 3, and control bit 8+(s-4) for slots 4 and 5. A value of 1 selects 32 MHz and 0 selects 8 MHz.
- R3: Output `auto_ack_en` follows control bit 5. Bit 4 is the timeout arm bit, bit 6 the interrupt enable and bit 7 the software test interrupt.
- R4: The pending register at offset 0x600 shows request line l of slot s at bit 2*s+l (bits 0 to 11). A bit reads 1 while its input `mod_irq_n` line is low. A change on an input line appears in the register after the third rising clock edge, and not after the second. Bits 15:12 read 0.
- R5: Writes to offset 0x600 do not change the pending bits. A pending bit falls only when its request line goes high.
- R6: While the arm bit is 0, the timeout status is 0, even if `tmo_evt` pulses.
- R7: While the arm bit is 1, a `tmo_evt` pulse sets the timeout status on the next edge. The status stays set, even with later pulses, until the arm bit is written 0. After that it reads 0 one edge after the write.
- R8: The status register at offset 0x700 has the timeout status at bit 6 and an active-high copy of the local interrupt at bit 7. All other bits read 0, and writes to it are ignored.
- R9: `lint_n` is low exactly when the interrupt enable is 1 and at least one source is active: any pending bit, the timeout status, or the test bit. With the enable at 0 the output stays high, and the sources stay visible in their registers.
- R10: Setting the test bit while the enable is 1 drives `lint_n` low even with no other source.
- R11: Reads of any other address return 0, and writes to any other address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 12 | Word register byte offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| mod_irq_n | input | 12 | Asynchronous active-low module requests, slot-major |
| tmo_evt | input | 1 | One-cycle bus-timeout event |
| slot_clk_fast | output | 6 | Per-slot clock select, 1 = 32 MHz |
| auto_ack_en | output | 1 | Timeout auto-acknowledge enable |
| lint_n | output | 1 | Active-low local interrupt |

## Verification
The bench walks a single low level across all twelve request lines. It checks that each lands on its own bit, which would catch a slot-major versus line-major swap. It also checks that nothing shows after two edges and that the bit is present after three, which exposes a missing or extra synchronizer stage.

It sweeps every combination of enable, test bit, timeout status and one module request against the interrupt output. A design that gated only some sources, or that let sources through with the enable at 0, would mismatch there.

The hold-clear flag is probed three ways: pulses while disarmed, a repeat pulse while set, and the clear after the arm bit is rewritten. A write-one-to-clear design or a non-sticky flag would fail these checks. Writes to the read-only offsets and to an unmapped offset are read back to confirm that no register moved.

// File: rtl/carrier_irq_pkg.sv
package carrier_irq_pkg;

    parameter int NUM_SLOTS      = 6;
    parameter int LINES_PER_SLOT = 2;
    parameter int REG_W          = 16;
    parameter int ADDR_W         = 12;
    parameter int SYNC_STAGES    = 2;

    localparam int NUM_IRQ = NUM_SLOTS * LINES_PER_SLOT;
    localparam int LO_CLK  = 4;                 // slots with select in bits 3:0
    localparam int HI_CLK  = NUM_SLOTS - LO_CLK; // slots with select in bits 9:8
    localparam int CTL_USED = 10;

    localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'('h500);
    localparam logic [ADDR_W-1:0] OFS_PEND = ADDR_W'('h600);
    localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'('h700);

    localparam logic [REG_W-1:0] CTRL_MASK = REG_W'((1 << CTL_USED) - 1);

    localparam int STAT_TMO_BIT  = 6;
    localparam int STAT_LINT_BIT = 7;

    // Control register view, msb first: bits 9:0
    typedef struct packed {
        logic [HI_CLK-1:0] clk_hi;
        logic              test_irq;
        logic              irq_en;
        logic              ack_en;
        logic              tmo_arm;
        logic [LO_CLK-1:0] clk_lo;
    } ctrl_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_PEND = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

    function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
        if (a == OFS_CTRL)      return SEL_CTRL;
        else if (a == OFS_PEND) return SEL_PEND;
        else if (a == OFS_STAT) return SEL_STAT;
        else                    return SEL_NONE;
    endfunction

    function automatic logic [NUM_SLOTS-1:0] clk_sel(input ctrl_t c);
        return {c.clk_hi, c.clk_lo};
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH  = 12,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din_n,
    output logic [WIDTH-1:0] dout_n
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk) begin
            if (rst) chain_q <= '1;
            else     chain_q <= {chain_q[STAGES-2:0], din_n[i]};
        end
        assign dout_n[i] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/ctl_regs.sv
module ctl_regs
    import carrier_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctrl,
    input  logic [REG_W-1:0] wdata,
    input  logic             tmo_evt,
    output logic [REG_W-1:0] ctrl_word,
    output ctrl_t            ctrl,
    output logic             tmo_flag
);
    logic [REG_W-1:0] ctrl_q;
    logic             flag_q;

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= wdata & CTRL_MASK;
    end

    assign ctrl      = ctrl_t'(ctrl_q[CTL_USED-1:0]);
    assign ctrl_word = ctrl_q;

    // Hold-clear sticky flag: the arm bit low forces it clear
    always_ff @(posedge clk) begin
        if (rst || !ctrl.tmo_arm) flag_q <= 1'b0;
        else if (tmo_evt)         flag_q <= 1'b1;
    end
    assign tmo_flag = flag_q;

    p_hold_clear_r6: assert property (@(posedge clk) disable iff (rst)
        !ctrl.tmo_arm |=> !tmo_flag);
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (tmo_flag && ctrl.tmo_arm && !wr_ctrl) |=> tmo_flag);
    p_set_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.tmo_arm && tmo_evt && !wr_ctrl) |=> tmo_flag);
    p_ctrl_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> $stable(ctrl_word));
endmodule

// File: rtl/carrier_irq_ctrl.sv
module carrier_irq_ctrl
    import carrier_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic [NUM_IRQ-1:0]   mod_irq_n,
    input  logic                 tmo_evt,
    output logic [NUM_SLOTS-1:0] slot_clk_fast,
    output logic                 auto_ack_en,
    output logic                 lint_n
);
    reg_sel_e           sel;
    logic [NUM_IRQ-1:0] sync_n;
    logic [NUM_IRQ-1:0] pend_q;
    logic [REG_W-1:0]   ctrl_word;
    ctrl_t              ctrl;
    logic               tmo_flag;
    logic               lint;

    assign sel = decode(reg_addr);

    irq_sync #(.WIDTH(NUM_IRQ), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din_n(mod_irq_n), .dout_n(sync_n)
    );

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= ~sync_n;
    end

    ctl_regs u_regs (
        .clk(clk), .rst(rst),
        .wr_ctrl(reg_wr && sel == SEL_CTRL),
        .wdata(reg_wdata), .tmo_evt(tmo_evt),
        .ctrl_word(ctrl_word), .ctrl(ctrl), .tmo_flag(tmo_flag)
    );

    assign lint          = ctrl.irq_en & ((|pend_q) | tmo_flag | ctrl.test_irq);
    assign lint_n        = ~lint;
    assign slot_clk_fast = clk_sel(ctrl);
    assign auto_ack_en   = ctrl.ack_en;

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_CTRL: reg_rdata = ctrl_word;
            SEL_PEND: reg_rdata[NUM_IRQ-1:0] = pend_q;
            SEL_STAT: begin
                reg_rdata[STAT_TMO_BIT]  = tmo_flag;
                reg_rdata[STAT_LINT_BIT] = lint;
            end
            default:  reg_rdata = '0;
        endcase
    end

    p_blocked_r9: assert property (@(posedge clk) disable iff (rst)
        !ctrl.irq_en |-> lint_n);
    p_test_r10: assert property (@(posedge clk) disable iff (rst)
        (ctrl.irq_en && ctrl.test_irq) |-> !lint_n);
    p_pend_ro_r5: assert property (@(posedge clk) disable iff (rst)
        (pend_q[0] && !sync_n[0]) |=> pend_q[0]);
endmodule

// File: tb/carrier_irq_ctrl_tb_top.sv
module carrier_irq_ctrl_tb_top;
    logic        clk = 0;
    logic        rst = 1;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [11:0] mod_irq_n = '1;
    logic        tmo_evt = 0;
    logic [5:0]  slot_clk_fast;
    logic        auto_ack_en;
    logic        lint_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    carrier_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mod_irq_n(mod_irq_n),
        .tmo_evt(tmo_evt), .slot_clk_fast(slot_clk_fast),
        .auto_ack_en(auto_ack_en), .lint_n(lint_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_tmo();
        @(negedge clk);
        tmo_evt = 1;
        @(negedge clk);
        tmo_evt = 0;
    endtask

    // Control word from fields: bit4 arm, bit5 ack, bit6 enable, bit7 test
    function automatic logic [15:0] cw(bit en, bit tst, bit arm);
        return 16'((int'(tst) << 7) | (int'(en) << 6) | (int'(arm) << 4));
    endfunction

    initial begin
        logic [15:0] d;
        cyc(3);
        rst = 0;
        cyc(1);
        // R1 reset state
        rd(12'h500, d); chk("R1 reset ctrl", d, 0);
        rd(12'h600, d); chk("R4 reset pend", d, 0);
        rd(12'h700, d); chk("R8 reset stat", d, 0);
        chk("R9 reset lint_n", lint_n, 1);

        // R1/R2/R3 sweep of each control bit
        for (int b = 0; b < 16; b++) begin
            logic [15:0] exp_w;
            logic [5:0]  exp_c;
            wr(12'h500, 16'(1 << b));
            exp_w = (b < 10) ? 16'(1 << b) : 16'h0;
            rd(12'h500, d); chk("R1 ctrl readback", d, exp_w);
            exp_c = (b < 4) ? 6'(1 << b) : (b == 8 || b == 9) ? 6'(1 << (b - 4)) : 6'h0;
            chk("R2 clock select", slot_clk_fast, exp_c);
            chk("R3 auto ack", auto_ack_en, b == 5);
        end
        wr(12'h500, 16'h03FF);
        rd(12'h500, d); chk("R1 all bits", d, 16'h03FF);
        chk("R2 all fast", slot_clk_fast, 6'h3F);
        wr(12'h500, 16'h0);

        // R4 walking request with latency
        for (int l = 0; l < 12; l++) begin
            @(negedge clk);
            mod_irq_n = ~12'(1 << l);
            @(posedge clk); @(posedge clk);
            @(negedge clk);
            rd(12'h600, d); chk("R4 not after two edges", d, 0);
            @(negedge clk);
            rd(12'h600, d); chk("R4 pending bit", d, 16'(1 << l));
            wr(12'h600, 16'h0000);
            rd(12'h600, d); chk("R5 write ignored", d, 16'(1 << l));
            chk("R9 blocked while disabled", lint_n, 1);
            mod_irq_n = '1;
            cyc(4);
            rd(12'h600, d); chk("R5 clears on release", d, 0);
        end

        // R6 disarmed pulse ignored
        pulse_tmo();
        rd(12'h700, d); chk("R6 held clear", d, 0);
        // R7 armed set, sticky, clear on disarm
        wr(12'h500, cw(0, 0, 1));
        pulse_tmo();
        rd(12'h700, d); chk("R7 set", d, 16'h0040);
        pulse_tmo();
        cyc(2);
        rd(12'h700, d); chk("R7 sticky", d, 16'h0040);
        wr(12'h700, 16'h0000);
        rd(12'h700, d); chk("R8 write ignored", d, 16'h0040);
        wr(12'h500, cw(0, 0, 0));
        @(negedge clk);
        rd(12'h700, d); chk("R7 clear on disarm", d, 0);
        wr(12'h500, cw(0, 0, 1));
        cyc(1);
        rd(12'h700, d); chk("R7 rearm stays clear", d, 0);

        // R9/R10 sweep of enable, test, timeout, request
        for (int c = 0; c < 16; c++) begin
            bit en, tst, ts, rq, exp_l;
            en = c[0]; tst = c[1]; ts = c[2]; rq = c[3];
            wr(12'h500, cw(0, 0, 0));
            @(negedge clk);
            mod_irq_n = rq ? ~12'h020 : 12'hFFF;
            wr(12'h500, cw(en, tst, ts));
            if (ts) pulse_tmo();
            cyc(4);
            exp_l = en & (tst | ts | rq);
            chk(tst && en ? "R10 test forces" : "R9 gating", lint_n, !exp_l);
            rd(12'h700, d);
            chk("R8 status bits", d, 16'((int'(exp_l) << 7) | (int'(ts) << 6)));
            rd(12'h600, d); chk("R9 pending kept", d, rq ? 16'h0020 : 16'h0);
        end
        mod_irq_n = '1;

        // R11 other addresses
        wr(12'h500, 16'h0155);
        wr(12'h400, 16'hFFFF);
        wr(12'h501, 16'hFFFF);
        rd(12'h500, d); chk("R11 stray write", d, 16'h0155);
        rd(12'h400, d); chk("R11 unmapped read", d, 0);
        rd(12'h7FF, d); chk("R11 unmapped read high", d, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule